// File: doc/BRIEF.md
# Source Address Pending-Frame Matcher

This block keeps a small table of device addresses for which data is waiting. It checks the source of every received data or command frame against that table. The result sets the Frame Pending bit of the automatic immediate acknowledgement. The block also decides whether that acknowledgement is requested at all.

The table is one storage area of `N_SHORT` 32-bit words. It holds either short entries or extended entries:

- **Short entry:** one word, with the PAN identifier in the upper half and the 16-bit short address in the lower half.
- **Extended entry:** two adjacent words holding a 64-bit address.

Each entry has its own enable bit. Firmware must not enable a short entry and an extended entry that overlap.

**Lookup.** A header handed in with a valid strobe starts a sequential scan, one entry per clock. A done strobe marks the end of the scan.

**Acknowledgement request.** One clock after the done strobe, the block pulses the request to the transmitter. The request carries the received sequence number and the final pending bit.

Top module: `src_pend_match`

## Requirements
- R1: Writes: `wr_addr` 0..N_SHORT-1 loads table word k. For a short entry k, bits [31:16] are the PAN and bits [15:0] are the short address. Extended entry j takes its low 32 bits from word 2j and its high 32 bits from word 2j+1. Address N_SHORT loads the short-enable mask (bit k enables short entry k). Address N_SHORT+1 loads the extended-enable mask (bit j). Address N_SHORT+2 bit 0 is the auto-acknowledge enable. At reset all enables are 0 and auto-acknowledge is 1.
- R2: With source mode 2, the lookup hits when an enabled short entry equals the header's source PAN and source short address (`hdr_src_addr[15:0]`).
- R3: With source mode 3, the lookup hits when an enabled extended entry equals the 64-bit `hdr_src_addr`.
- R4: Disabled entries never hit. Source modes 0 and 1 never hit.
- R5: `ack_req` pulses only when all of these hold: auto-acknowledge is enabled, the frame type is data (1) or command (3), the version is 0 or 1, ack-request is set, and the frame is not broadcast. `ack_seq` then carries the header's sequence number.
- R6: Frames with version 2 or 3 never raise `ack_req`.
- R7: `lookup_done` is a one-clock pulse. It comes L clocks after the edge that accepts the header, with L = N_SHORT for mode 2, N_SHORT/2 for mode 3 and 1 otherwise. `hdr_valid` is ignored while a lookup runs.
- R8: `ack_req` rises exactly one clock after `lookup_done`. `ack_pend` equals the lookup hit: 1 on a match and 0 when there is none.
- R9: After auto-acknowledge is written to 0, no `ack_req` is produced. Lookups and `lookup_done` still run.
- R10: After reset, `lookup_done`, `ack_req`, `ack_pend` and `ack_seq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register address |
| wr_data | input | 32 | Register write data |
| hdr_valid | input | 1 | Parsed header strobe |
| hdr_ftype | input | 3 | Frame type |
| hdr_ver | input | 2 | Frame version |
| hdr_ackreq | input | 1 | Ack-request flag of the frame |
| hdr_bcast | input | 1 | Destination is broadcast |
| hdr_seq | input | 8 | Sequence number |
| hdr_src_mode | input | 2 | Source addressing mode |
| hdr_src_pan | input | 16 | Source PAN identifier |
| hdr_src_addr | input | 64 | Source address (short form in bits 15:0) |
| lookup_done | output | 1 | Lookup finished (pulse) |
| lookup_hit | output | 1 | Lookup result, valid with `lookup_done` |
| ack_req | output | 1 | Immediate-acknowledge request (pulse) |
| ack_seq | output | 8 | Sequence number for the acknowledgement |
| ack_pend | output | 1 | Frame Pending bit for the acknowledgement |

## Verification
The lookup is driven with a set of distinct cases:

- Short and extended matches, including the last slot of each kind. These show whether the comparison covers the full index range and uses the right word order for extended entries.
- Mismatching addresses, disabled entries and source modes 0 and 1. These separate a genuine match from a stale or forced one.
- Headers that vary one acknowledge condition at a time: type, version, broadcast, ack-request and the enable. These isolate each term of the acknowledge decision.
- A second header sent while a lookup is running. This shows that the busy scan is not restarted.

// File: rtl/src_pend_match.sv
module src_pend_match #(
  parameter int N_SHORT = 32,
  localparam int AW = $clog2(N_SHORT + 3)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic          hdr_valid,
  input  logic [2:0]    hdr_ftype,
  input  logic [1:0]    hdr_ver,
  input  logic          hdr_ackreq,
  input  logic          hdr_bcast,
  input  logic [7:0]    hdr_seq,
  input  logic [1:0]    hdr_src_mode,
  input  logic [15:0]   hdr_src_pan,
  input  logic [63:0]   hdr_src_addr,
  output logic          lookup_done,
  output logic          lookup_hit,
  output logic          ack_req,
  output logic [7:0]    ack_seq,
  output logic          ack_pend
);
  localparam int N_EXT = N_SHORT / 2;
  localparam int IW = $clog2(N_SHORT);

  logic [31:0]      tbl [N_SHORT];
  logic [N_SHORT-1:0] s_en;
  logic [N_EXT-1:0] x_en;
  logic             ack_en;

  always_ff @(posedge clk)
    if (wr_en && int'(wr_addr) < N_SHORT) tbl[wr_addr[IW-1:0]] <= wr_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s_en <= '0; x_en <= '0; ack_en <= 1'b1;
    end else if (wr_en) begin
      if (wr_addr == AW'(N_SHORT))     s_en   <= wr_data[N_SHORT-1:0];
      if (wr_addr == AW'(N_SHORT + 1)) x_en   <= wr_data[N_EXT-1:0];
      if (wr_addr == AW'(N_SHORT + 2)) ack_en <= wr_data[0];
    end

  logic          busy, elig_q, hit_q;
  logic [IW-1:0] idx, last_q;
  logic [1:0]    mode_q;
  logic [15:0]   pan_q;
  logic [63:0]   addr_q;
  logic [7:0]    seq_q;

  wire [IW-2:0] eidx  = idx[IW-2:0];
  wire [31:0]   ext_lo = tbl[{eidx, 1'b0}];
  wire [31:0]   ext_hi = tbl[{eidx, 1'b1}];
  wire s_hit = (mode_q == 2'd2) && s_en[idx] && (tbl[idx] == {pan_q, addr_q[15:0]});
  wire x_hit = (mode_q == 2'd3) && x_en[eidx] && ({ext_hi, ext_lo} == addr_q);

  wire hdr_elig = ack_en && !hdr_bcast && hdr_ackreq && (hdr_ver < 2'd2) &&
                  (hdr_ftype == 3'd1 || hdr_ftype == 3'd3);
  wire [IW-1:0] hdr_last = (hdr_src_mode == 2'd2) ? IW'(N_SHORT - 1) :
                           (hdr_src_mode == 2'd3) ? IW'(N_EXT - 1) : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0; idx <= '0; last_q <= '0; mode_q <= '0; pan_q <= '0;
      addr_q <= '0; seq_q <= '0; elig_q <= 1'b0; hit_q <= 1'b0;
      lookup_done <= 1'b0; ack_req <= 1'b0; ack_seq <= '0; ack_pend <= 1'b0;
    end else begin
      lookup_done <= 1'b0;
      ack_req     <= lookup_done && elig_q;
      if (lookup_done) begin
        ack_seq  <= seq_q;
        ack_pend <= hit_q;
      end
      if (!busy && hdr_valid) begin
        busy   <= 1'b1;
        idx    <= '0;
        last_q <= hdr_last;
        mode_q <= hdr_src_mode;
        pan_q  <= hdr_src_pan;
        addr_q <= hdr_src_addr;
        seq_q  <= hdr_seq;
        elig_q <= hdr_elig;
        hit_q  <= 1'b0;
      end else if (busy) begin
        hit_q <= hit_q | s_hit | x_hit;
        idx   <= idx + 1'b1;
        if (idx == last_q) begin
          busy        <= 1'b0;
          lookup_done <= 1'b1;
        end
      end
    end

  assign lookup_hit = hit_q;

  logic [IW:0] busy_cnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) busy_cnt <= '0;
    else        busy_cnt <= busy ? busy_cnt + 1'b1 : '0;

  AST_SCAN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n) busy_cnt <= (IW+1)'(N_SHORT)); // R7
  AST_DONE_FROM_SCAN: assert property (@(posedge clk) disable iff (!rst_n) $rose(lookup_done) |-> $past(busy)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) lookup_done |=> !lookup_done); // R7
  AST_ACK_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n) ack_req |-> $past(lookup_done)); // R8
  AST_SEQ_HELD: assert property (@(posedge clk) disable iff (!rst_n) !lookup_done |=> $stable(ack_seq)); // R5
  AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n) !lookup_done |=> $stable(ack_pend)); // R8
endmodule

// File: tb/sim_src_pend_match.sv
module sim_src_pend_match;
  localparam int NS = 32;
  localparam int NX = NS / 2;
  localparam int AW = $clog2(NS + 3);

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic hdr_valid = 1'b0, hdr_ackreq = 1'b0, hdr_bcast = 1'b0;
  logic [2:0] hdr_ftype = '0;
  logic [1:0] hdr_ver = '0, hdr_src_mode = '0;
  logic [7:0] hdr_seq = '0;
  logic [15:0] hdr_src_pan = '0;
  logic [63:0] hdr_src_addr = '0;
  logic lookup_done, lookup_hit, ack_req, ack_pend;
  logic [7:0] ack_seq;

  always #5 clk = ~clk;

  src_pend_match #(.N_SHORT(NS)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hdr_valid(hdr_valid), .hdr_ftype(hdr_ftype), .hdr_ver(hdr_ver),
    .hdr_ackreq(hdr_ackreq), .hdr_bcast(hdr_bcast), .hdr_seq(hdr_seq),
    .hdr_src_mode(hdr_src_mode), .hdr_src_pan(hdr_src_pan), .hdr_src_addr(hdr_src_addr),
    .lookup_done(lookup_done), .lookup_hit(lookup_hit), .ack_req(ack_req),
    .ack_seq(ack_seq), .ack_pend(ack_pend));

  int compared = 0, mismatched = 0, cycles = 0;

  // behavioural reference
  logic [31:0] m_tbl [NS];
  logic [NS-1:0] m_sen;
  logic [NX-1:0] m_xen;
  logic m_acken, m_busy, m_hit, m_elig, m_done, m_ackreq, m_ackpend;
  int m_left;
  logic [7:0] m_seq, m_ackseq;

  function automatic logic ref_hit(logic [1:0] md, logic [15:0] pan, logic [63:0] a);
    logic h = 1'b0;
    if (md == 2'd2)
      for (int i = 0; i < NS; i++) if (m_sen[i] && m_tbl[i] == {pan, a[15:0]}) h = 1'b1;
    if (md == 2'd3)
      for (int j = 0; j < NX; j++) if (m_xen[j] && {m_tbl[2*j+1], m_tbl[2*j]} == a) h = 1'b1;
    return h;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sen = '0; m_xen = '0; m_acken = 1'b1; m_busy = 1'b0; m_hit = 1'b0;
      m_elig = 1'b0; m_done = 1'b0; m_ackreq = 1'b0; m_ackpend = 1'b0;
      m_ackseq = '0; m_seq = '0; m_left = 0;
    end else begin
      m_ackreq = m_done && m_elig;
      if (m_done) begin m_ackseq = m_seq; m_ackpend = m_hit; end
      m_done = 1'b0;
      if (!m_busy && hdr_valid) begin
        m_busy = 1'b1;
        m_left = (hdr_src_mode == 2'd2) ? NS : (hdr_src_mode == 2'd3) ? NX : 1;
        m_hit  = ref_hit(hdr_src_mode, hdr_src_pan, hdr_src_addr);
        m_seq  = hdr_seq;
        m_elig = m_acken && !hdr_bcast && hdr_ackreq && hdr_ver <= 1 &&
                 (hdr_ftype == 3'd1 || hdr_ftype == 3'd3);
      end else if (m_busy) begin
        m_left--;
        if (m_left == 0) begin m_busy = 1'b0; m_done = 1'b1; end
      end
      if (wr_en) begin
        if (int'(wr_addr) < NS) m_tbl[wr_addr] = wr_data;
        else if (int'(wr_addr) == NS) m_sen = wr_data[NS-1:0];
        else if (int'(wr_addr) == NS + 1) m_xen = wr_data[NX-1:0];
        else if (int'(wr_addr) == NS + 2) m_acken = wr_data[0];
      end
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cycles > 1) begin
    chk("R7 lookup_done", lookup_done, m_done);
    if (m_done) chk("R2 R3 R4 lookup_hit", lookup_hit, m_hit);
    chk("R5 R6 R9 ack_req", ack_req, m_ackreq);
    if (m_ackreq) begin
      chk("R5 ack_seq", ack_seq, m_ackseq);
      chk("R8 ack_pend", ack_pend, m_ackpend);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic hdr(logic [2:0] ft, logic [1:0] v, logic ar, logic bc, logic [7:0] sq,
                     logic [1:0] md, logic [15:0] pan, logic [63:0] a, bit wait_idle = 1);
    @(negedge clk);
    hdr_valid = 1'b1; hdr_ftype = ft; hdr_ver = v; hdr_ackreq = ar; hdr_bcast = bc;
    hdr_seq = sq; hdr_src_mode = md; hdr_src_pan = pan; hdr_src_addr = a;
    @(negedge clk); hdr_valid = 1'b0;
    if (wait_idle) repeat (NS + 4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 reset lookup_done", lookup_done, 0);
    chk("R10 reset ack_req", ack_req, 0);
    chk("R10 reset ack_pend", ack_pend, 0);
    chk("R10 reset ack_seq", ack_seq, 0);
    rst_n = 1'b1;
    // R1 table writes, R2 short match
    wr(5, 32'h1234_ABCD);
    wr(NS - 1, 32'hBEEF_0042);
    wr(NS, 32'h8000_0020);
    hdr(3'd1, 2'd1, 1, 0, 8'h11, 2'd2, 16'h1234, 64'hABCD);
    hdr(3'd3, 2'd0, 1, 0, 8'h12, 2'd2, 16'hBEEF, 64'h0042);   // R2 last slot
    hdr(3'd1, 2'd1, 1, 0, 8'h13, 2'd2, 16'h1234, 64'hABCE);   // R8 no match
    hdr(3'd1, 2'd1, 1, 0, 8'h14, 2'd2, 16'h1235, 64'hABCD);   // R2 PAN differs
    // R4 disabled entry
    wr(NS, 32'h8000_0000);
    hdr(3'd1, 2'd1, 1, 0, 8'h15, 2'd2, 16'h1234, 64'hABCD);
    // R3 extended match, slots 3 and last
    wr(6, 32'h4455_6677); wr(7, 32'h0011_2233);
    wr(NS - 2, 32'hCAFE_F00D); wr(NS - 1, 32'hDEAD_BEEF);
    wr(NS + 1, 32'h0000_8008);
    hdr(3'd1, 2'd0, 1, 0, 8'h21, 2'd3, 16'h0, 64'h0011_2233_4455_6677);
    hdr(3'd1, 2'd0, 1, 0, 8'h22, 2'd3, 16'h0, 64'hDEAD_BEEF_CAFE_F00D);
    hdr(3'd1, 2'd0, 1, 0, 8'h23, 2'd3, 16'h0, 64'h4455_6677_0011_2233); // R3 word order
    // R4 modes 0 and 1 never match
    hdr(3'd1, 2'd1, 1, 0, 8'h31, 2'd1, 16'h0, 64'h0011_2233_4455_6677);
    hdr(3'd1, 2'd1, 1, 0, 8'h32, 2'd0, 16'h0, 64'h0);
    // R6 version 2 and 3, R5 broadcast, no ack request, beacon type
    hdr(3'd1, 2'd2, 1, 0, 8'h41, 2'd3, 16'h0, 64'h0011_2233_4455_6677);
    hdr(3'd3, 2'd3, 1, 0, 8'h42, 2'd3, 16'h0, 64'h0011_2233_4455_6677);
    hdr(3'd1, 2'd1, 1, 1, 8'h43, 2'd3, 16'h0, 64'h0011_2233_4455_6677);
    hdr(3'd1, 2'd1, 0, 0, 8'h44, 2'd3, 16'h0, 64'h0011_2233_4455_6677);
    hdr(3'd0, 2'd1, 1, 0, 8'h45, 2'd3, 16'h0, 64'h0011_2233_4455_6677);
    hdr(3'd2, 2'd1, 1, 0, 8'h46, 2'd3, 16'h0, 64'h0011_2233_4455_6677);
    // R7 header while busy is ignored
    hdr(3'd1, 2'd1, 1, 0, 8'h51, 2'd3, 16'h0, 64'h0011_2233_4455_6677, 0);
    hdr(3'd1, 2'd1, 1, 0, 8'h52, 2'd1, 16'h0, 64'h0, 1);
    // R9 auto acknowledge disabled, then enabled again
    wr(NS + 2, 32'h0);
    hdr(3'd1, 2'd1, 1, 0, 8'h61, 2'd3, 16'h0, 64'h0011_2233_4455_6677);
    wr(NS + 2, 32'h1);
    hdr(3'd3, 2'd1, 1, 0, 8'h62, 2'd3, 16'h0, 64'h0011_2233_4455_6677);
    // R7 back-to-back accepted right after done
    hdr(3'd1, 2'd0, 1, 0, 8'h71, 2'd0, 16'h0, 64'h0, 0);
    @(negedge clk);
    hdr(3'd1, 2'd0, 1, 0, 8'h72, 2'd3, 16'h0, 64'hDEAD_BEEF_CAFE_F00D);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule